// File: doc/BRIEF.md
# Exception Return Link Builder

This block forms the 32-bit return link value that a microcontroller-class core writes into its link register when it enters an exception. The value records several facts that exception return relies on:

- which security state to return to;
- which security state the handler runs in;
- whether the core came from thread mode;
- which stack pointer was selected;
- whether the callee-saved registers still need to be unstacked.

The block also decides whether the entry must push the callee-saved registers. That push is needed when Secure background code is interrupted by a Non-secure handler.

The value is built in two ordered phases.

- **First phase.** On a fresh entry it makes a base value from the core's current state. On a tail-chained entry it takes the incoming link value unchanged.
- **Second phase.** When the v8 feature strap is set, it applies the security-aware rules for the target state: the callee-save flag, the handler-state flag and the stack-select bit.

Each phase is one register stage. A `start` strobe samples the inputs. Two clock edges later a one-cycle `done` pulse presents the link value, together with any push request. The value then holds until the next result. A new request may be started on every cycle.

Bit layout used throughout:

| Bit(s) | Meaning |
|---|---|
| 0 | handler-state flag (ES) |
| 1 | always zero on fresh entry |
| 2 | stack-select (SPSEL) |
| 3 | thread-mode flag (MODE) |
| 4 | frame-type (FTYPE) |
| 5 | callee-save-done flag (DCRS) |
| 6 | return-state flag (S) |
| 31:7 | all ones on fresh entry |

Top module: `excret_builder`

## Requirements
- R1: During reset and in the first cycle after it, `done`, `push_callee` and `link_out` are all zero.
- R2: On a fresh entry with `has_v8`=1, before the second phase: bits 31:7 are ones, bit 1 is zero, FTYPE (bit 4) and DCRS (bit 5) are set, and S (bit 6) equals `cur_secure`.
- R3: On a fresh entry with `has_v8`=0, the result has bits 31:7, S, DCRS, FTYPE and ES (bit 0) set, bit 1 clear, and SPSEL (bit 2) equal to `spsel_ns`. `push_callee` is 0.
- R4: On a fresh entry MODE (bit 3) equals `in_thread`. On a tail-chained entry every bit other than ES, SPSEL and DCRS is taken from `link_in`.
- R5: With `has_v8`=1 and `has_sec`=1, if the working value has S set, the target is Secure, the entry is tail-chained and ES is clear in `link_in`, then DCRS is cleared. Otherwise a Secure target leaves DCRS unchanged.
- R6: With `has_v8`=1 and `has_sec`=1, a working value with S set, and a Non-secure target:
  - `push_callee` is 1 when DCRS is set, unless the entry is tail-chained with ES set in `link_in`;
  - DCRS is forced to 1 in the result.
- R7: With `has_v8`=1, ES in the result is 1 exactly when `tgt_secure`=1 or `has_sec`=0.
- R8: With `has_v8`=1, SPSEL in the result equals `spsel_s` for a Secure target and `spsel_ns` for a Non-secure target.
- R9: With `has_v8`=0 and a tail-chained entry, `link_out` equals `link_in` and `push_callee` is 0.
- R10: Timing and handshake:
  - `done` is high for exactly one cycle, two clock edges after the edge that samples `start`;
  - `push_callee` is high only together with `done`;
  - `link_out` does not change in a cycle without `done`;
  - back-to-back starts give back-to-back results, in order.
- R11: With `has_v8`=1 and either S clear in the working value or `has_sec`=0, DCRS is passed through from the first phase and `push_callee` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample the request inputs this cycle |
| cur_secure | input | 1 | Core is currently in the Secure state |
| tgt_secure | input | 1 | Exception is taken to the Secure state |
| in_thread | input | 1 | Exception is taken from thread mode |
| spsel_ns | input | 1 | Stack-select bit of the Non-secure control register |
| spsel_s | input | 1 | Stack-select bit of the Secure control register |
| tail_chain | input | 1 | Entry is tail-chained and reuses `link_in` |
| link_in | input | LINK_W | Previous link value, used when tail-chaining |
| has_v8 | input | 1 | v8 feature strap |
| has_sec | input | 1 | Security extension strap |
| link_out | output | LINK_W | Final link value, valid with `done` and held afterwards |
| push_callee | output | 1 | Callee-saved registers must be pushed; valid with `done` |
| done | output | 1 | One-cycle result strobe |

## Verification
The bench goes after the tail-chain corners, where the incoming ES and DCRS bits decide the outcome:

- **Secure target, ES clear.** A design that skipped clearing DCRS would return without unstacking the callee-saved registers.
- **Non-secure target, ES already set.** A design that ignored the ES check would push the callee-saved registers a second time.
- **Non-secure target, DCRS clear.** Dropping the forced DCRS would leave DCRS clear.

Beyond these corners, the bench checks:

- that the ES and SPSEL rewrites happen only when the v8 strap is set;
- that the non-v8 path keeps its own SPSEL source;
- a full sweep of every strap, state and flag combination, issued back-to-back, where a stage that dropped or reordered a result would shift every later comparison.

// File: rtl/excret_pkg.sv
package excret_pkg;

  // Bit positions of the link value fields (behaviour depends on them).
  localparam int ES_BIT     = 0;
  localparam int ZERO_BIT   = 1;
  localparam int SPSEL_BIT  = 2;
  localparam int MODE_BIT   = 3;
  localparam int FTYPE_BIT  = 4;
  localparam int DCRS_BIT   = 5;
  localparam int S_BIT      = 6;
  localparam int PREFIX_LSB = 7;

  // Request context carried from the first stage to the second.
  typedef struct packed {
    logic tgt_secure;
    logic tail;
    logic spsel_s;
    logic spsel_ns;
    logic has_v8;
    logic has_sec;
  } entry_ctx_t;

endpackage

// File: rtl/excret_base.sv
module excret_base
  import excret_pkg::*;
#(
  parameter int LINK_W = 32
) (
  input  logic              has_v8,
  input  logic              cur_secure,
  input  logic              in_thread,
  input  logic              spsel_ns,
  input  logic              tail,
  input  logic [LINK_W-1:0] link_in,
  output logic [LINK_W-1:0] base
);

  localparam int PREFIX_W = LINK_W - PREFIX_LSB;
  localparam logic [LINK_W-1:0] PREFIX = {{PREFIX_W{1'b1}}, {PREFIX_LSB{1'b0}}};

  // First phase: tail-chained entries reuse the previous value untouched.
  always_comb begin
    if (tail) begin
      base = link_in;
    end else begin
      base = PREFIX;
      base[FTYPE_BIT] = 1'b1;
      base[DCRS_BIT]  = 1'b1;
      base[MODE_BIT]  = in_thread;
      if (has_v8) begin
        // ES and SPSEL are settled by the second phase.
        base[S_BIT] = cur_secure;
      end else begin
        base[S_BIT]     = 1'b1;
        base[ES_BIT]    = 1'b1;
        base[SPSEL_BIT] = spsel_ns;
      end
    end
  end

endmodule

// File: rtl/excret_fixup.sv
module excret_fixup
  import excret_pkg::*;
#(
  parameter int LINK_W = 32
) (
  input  entry_ctx_t        ctx,
  input  logic [LINK_W-1:0] base,
  output logic [LINK_W-1:0] link,
  output logic              push
);

  // Second phase, applied in a fixed order: callee-save flag first,
  // then the handler-state flag, then the stack-select bit.
  always_comb begin
    link = base;
    push = 1'b0;
    if (ctx.has_v8) begin
      if (ctx.has_sec && base[S_BIT]) begin
        if (ctx.tgt_secure) begin
          if (ctx.tail && !base[ES_BIT])
            link[DCRS_BIT] = 1'b0;
        end else begin
          push = base[DCRS_BIT] && !(ctx.tail && base[ES_BIT]);
          link[DCRS_BIT] = 1'b1;
        end
      end
      link[ES_BIT]    = ctx.tgt_secure || !ctx.has_sec;
      link[SPSEL_BIT] = ctx.tgt_secure ? ctx.spsel_s : ctx.spsel_ns;
    end
  end

endmodule

// File: rtl/excret_builder.sv
module excret_builder
  import excret_pkg::*;
#(
  parameter int LINK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cur_secure,
  input  logic              tgt_secure,
  input  logic              in_thread,
  input  logic              spsel_ns,
  input  logic              spsel_s,
  input  logic              tail_chain,
  input  logic [LINK_W-1:0] link_in,
  input  logic              has_v8,
  input  logic              has_sec,
  output logic [LINK_W-1:0] link_out,
  output logic              push_callee,
  output logic              done
);

  logic [LINK_W-1:0] base_c;
  logic [LINK_W-1:0] fix_c;
  logic              push_c;

  logic              s1_valid;
  logic [LINK_W-1:0] s1_base;
  entry_ctx_t        s1_ctx;
  entry_ctx_t        req_ctx;

  assign req_ctx = '{tgt_secure: tgt_secure, tail: tail_chain, spsel_s: spsel_s,
                     spsel_ns: spsel_ns, has_v8: has_v8, has_sec: has_sec};

  excret_base #(.LINK_W(LINK_W)) u_base (
    .has_v8     (has_v8),
    .cur_secure (cur_secure),
    .in_thread  (in_thread),
    .spsel_ns   (spsel_ns),
    .tail       (tail_chain),
    .link_in    (link_in),
    .base       (base_c)
  );

  // Stage 1: capture the first-phase value and the request context.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_base  <= '0;
      s1_ctx   <= '0;
    end else begin
      s1_valid <= start;
      if (start) begin
        s1_base <= base_c;
        s1_ctx  <= req_ctx;
      end
    end
  end

  excret_fixup #(.LINK_W(LINK_W)) u_fix (
    .ctx  (s1_ctx),
    .base (s1_base),
    .link (fix_c),
    .push (push_c)
  );

  // Stage 2: registered outputs; the link value holds between results.
  always_ff @(posedge clk) begin
    if (rst) begin
      link_out    <= '0;
      push_callee <= 1'b0;
      done        <= 1'b0;
    end else begin
      done        <= s1_valid;
      push_callee <= s1_valid && push_c;
      if (s1_valid)
        link_out <= fix_c;
    end
  end

  // ---------------- assertions ----------------
  assert_push_only_on_done_R10: assert property (@(posedge clk) disable iff (rst)
    push_callee |-> done);

  assert_done_latency_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start, 2));

  assert_link_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(link_out));

  assert_push_marks_dcrs_R6: assert property (@(posedge clk) disable iff (rst)
    push_callee |-> (link_out[DCRS_BIT] && !link_out[ES_BIT]));

  assert_es_rule_R7: assert property (@(posedge clk) disable iff (rst)
    (done && $past(s1_ctx.has_v8)) |->
      (link_out[ES_BIT] == ($past(s1_ctx.tgt_secure) || !$past(s1_ctx.has_sec))));

  assert_secure_tail_dcrs_R5: assert property (@(posedge clk) disable iff (rst)
    (done && $past(s1_ctx.has_v8 && s1_ctx.has_sec && s1_ctx.tgt_secure && s1_ctx.tail
                   && s1_base[S_BIT] && !s1_base[ES_BIT])) |-> !link_out[DCRS_BIT]);

  assert_legacy_fresh_R3: assert property (@(posedge clk) disable iff (rst)
    (done && $past(!s1_ctx.has_v8 && !s1_ctx.tail)) |->
      (link_out[S_BIT] && link_out[ES_BIT] && link_out[DCRS_BIT] && !push_callee));

endmodule

// File: tb/excret_builder_bench.sv
`timescale 1ns/1ps
module excret_builder_bench;

  localparam int W = 32;
  localparam int MAX_CYC = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cur_secure = 0, tgt_secure = 0, in_thread = 0, spsel_ns = 0, spsel_s = 0;
  logic tail_chain = 0, has_v8 = 0, has_sec = 0;
  logic [W-1:0] link_in = '0;
  logic [W-1:0] link_out;
  logic push_callee, done;

  always #10 clk = ~clk;

  excret_builder #(.LINK_W(W)) u_excret_builder (
    .clk(clk), .rst(rst), .start(start), .cur_secure(cur_secure),
    .tgt_secure(tgt_secure), .in_thread(in_thread), .spsel_ns(spsel_ns),
    .spsel_s(spsel_s), .tail_chain(tail_chain), .link_in(link_in),
    .has_v8(has_v8), .has_sec(has_sec), .link_out(link_out),
    .push_callee(push_callee), .done(done)
  );

  typedef struct {
    logic [W-1:0] link;
    logic         push;
    int           cyc;
    string        tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  logic [W-1:0] last_link = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  task automatic model(input logic cs, ts, thr, spn, sps, tl, v8, sc,
                       input logic [W-1:0] lin, output logic [W-1:0] lo,
                       output logic po);
    logic s, es, dc, sp;
    lo = tl ? lin : 32'hFFFF_FF80;
    if (!tl) begin
      lo[4] = 1'b1; lo[3] = thr;
      s = v8 ? cs : 1'b1; dc = 1'b1; es = !v8; sp = v8 ? 1'b0 : spn;
    end else begin
      s = lin[6]; dc = lin[5]; es = lin[0]; sp = lin[2];
    end
    po = 1'b0;
    if (v8) begin
      if (sc && s) begin
        if (ts) begin
          if (tl && !es) dc = 1'b0;
        end else begin
          po = dc && !(tl && es);
          dc = 1'b1;
        end
      end
      es = ts || !sc;
      sp = ts ? sps : spn;
    end
    lo[6] = s; lo[5] = dc; lo[2] = sp; lo[0] = es;
  endtask

  task automatic drive(input logic cs, ts, thr, spn, sps, tl, v8, sc,
                       input logic [W-1:0] lin, input string tag);
    item_t it;
    @(negedge clk);
    cur_secure = cs; tgt_secure = ts; in_thread = thr; spsel_ns = spn;
    spsel_s = sps; tail_chain = tl; has_v8 = v8; has_sec = sc; link_in = lin;
    start = 1'b1;
    model(cs, ts, thr, spn, sps, tl, v8, sc, lin, it.link, it.push);
    it.cyc = cyc + 2;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (done) begin
        if (q.size() == 0) begin
          check(1'b0, "R10 unexpected done", link_out, '0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(link_out == it.link, it.tag, link_out, it.link);
          check(push_callee == it.push, {it.tag, " push"}, W'(push_callee), W'(it.push));
          check(cyc == it.cyc, "R10 latency", W'(cyc), W'(it.cyc));
        end
      end else begin
        check(!push_callee, "R10 push without done", W'(push_callee), '0);
        check(link_out == last_link, "R10 hold", link_out, last_link);
      end
      last_link = link_out;
    end
  end

  initial begin
    #(20.0 * MAX_CYC);
    if (!finished) begin
      finished = 1;
      checks++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", q.size(), 0);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !push_callee && link_out == '0, "R1 reset state", link_out, '0);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !push_callee && link_out == '0, "R1 after reset", link_out, '0);

    // R2/R6: fresh v8, Secure thread code to Non-secure handler: push.
    drive(1,0,1,1,0,0,1,1, '0, "R2 R6 fresh S->NS");
    idle(3);
    // R2/R8: fresh v8, Non-secure handler to Non-secure.
    drive(0,0,0,0,1,0,1,1, '0, "R2 R8 fresh NS->NS");
    idle(3);
    // R7/R8: fresh v8 Secure to Secure.
    drive(1,1,1,0,1,0,1,1, '0, "R7 R8 fresh S->S");
    idle(3);
    // R3/R4: non-v8 fresh, spsel from NS control.
    drive(0,0,1,1,0,0,0,0, '0, "R3 R4 legacy fresh");
    idle(3);
    // R9: non-v8 tail chain passes link_in.
    drive(1,1,0,0,1,1,0,1, 32'hFFFF_FFAC, "R9 legacy tail");
    idle(3);
    // R5: tail to Secure, ES clear, S set: DCRS cleared.
    drive(1,1,0,0,0,1,1,1, 32'hFFFF_FFF8, "R5 tail clears DCRS");
    idle(3);
    // R6: tail to NS with ES set: no push, DCRS forced.
    drive(1,0,0,1,0,1,1,1, 32'hFFFF_FFF1, "R6 tail ES set no push");
    idle(3);
    // R6: tail to NS, DCRS clear: no push, DCRS set.
    drive(1,0,0,0,0,1,1,1, 32'hFFFF_FFD8, "R6 tail DCRS clear");
    idle(3);
    // R11: no security extension: ES=1, no push.
    drive(1,0,1,1,1,0,1,0, '0, "R11 no sec ext");
    idle(3);
    // R11/R4: S clear tail to NS keeps DCRS and MODE.
    drive(0,0,1,0,0,1,1,1, 32'hFFFF_FF88, "R11 R4 tail S clear");
    idle(3);

    // Full sweep, back-to-back (R10 ordering).
    for (int i = 0; i < 512; i++) begin
      logic [7:0] b;
      b = 8'(i);
      drive(b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7],
            {25'h1FF_FFFF, 7'(i * 53 + (i >> 3))}, "R10 sweep");
    end
    idle(6);
    check(q.size() == 0, "R10 all results seen", W'(q.size()), '0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule